// File: doc/BRIEF.md
# Two-Wire Target Port for Byte-Addressed RAM

This block lets an external two-wire bus controller read and write an on-chip byte RAM of either 2 kB or 4 kB. It oversamples the serial clock and data lines with the system clock and recognises its own 6-bit device address in the first byte after a START. It then either loads a 12-bit byte pointer from two address bytes and stores the data bytes that follow, or streams bytes out of the RAM starting at the pointer. Every access advances the pointer by one. The pointer wraps at the top of the selected RAM size.

The pointer keeps its value between transactions. A read that follows directly after a START therefore continues from the location just past the previous access. A random read is built from a write phase that only sets the pointer, then a repeated START and a read control byte. The RAM is reached through a synchronous port: a write strobe with address and data, and a read strobe whose data returns one clock later. The data line is open-drain. The block only ever asserts a pull-low enable, and it never holds the clock line low.

Top module: `i2c_mem_target`

## Requirements
- R1: The control byte is compared in bits 7:2 against the 6-bit device address, bit 1 is a don't-care and bit 0 selects read (1) or write (0); on a match the target pulls SDA low for the whole ninth clock.
- R2: On a device address mismatch the target leaves SDA released (NACK) and ignores all following bytes until the next START: no ACK, no RAM write, no pointer change.
- R3: In a write, the second byte supplies pointer bits 11:8 from its bits 3:0 (bits 7:4 ignored), the third byte supplies pointer bits 7:0, and both are ACKed.
- R4: Every write data byte is ACKed, stored at the current pointer, and the pointer then increases by one.
- R5: With `big_mode`=0 only pointer bits 10:0 address the RAM and the pointer steps from 0x7FF to 0x000.
- R6: With `big_mode`=1 the pointer steps from 0xFFF to 0x000.
- R7: The pointer is kept across STOP; a read control byte right after START returns the byte one past the last location accessed.
- R8: A write phase carrying only the two address bytes, followed by a repeated START and a read control byte, returns the byte at that address.
- R9: During a read, a controller ACK makes the target send the next byte, with the same increment and wrap as writes.
- R10: After a controller NACK on a read byte the target releases SDA and drives nothing until the next START; a STOP always leaves SDA released.
- R11: The target only begins pulling SDA low while SCL is low, and a START seen in the middle of a byte discards that byte and restarts control byte reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| big_mode | input | 1 | RAM size select: 0 = 2 kB, 1 = 4 kB |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| ram_we | output | 1 | RAM write strobe, one clock |
| ram_rd | output | 1 | RAM read strobe, data expected on `ram_rdata` one clock later |
| ram_addr | output | 12 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |

## Verification
A wrong byte-phase state shows up on the bus within one bit time. The target acknowledges a byte it should reject, stays silent on one it should accept, or drives a read bit where the controller expects to send. The bench samples each ACK slot in the middle of SCL high. A wrong pointer stays hidden longer: it only appears as data at the wrong RAM location, or as a wrong byte on the next read. For that reason, each scenario reads or inspects the RAM right after the access that moved the pointer, including across both wrap points and across a rejected transaction.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_TX,
    PH_RACK,
    PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    BK_CTRL,
    BK_AHI,
    BK_ALO,
    BK_DATA
  } bkind_t;
endpackage

// File: rtl/i2c_rst_sync.sv
module i2c_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh[0] <= scl_i;
      sda_sh[0] <= sda_i;
      for (int k = 1; k < SYNC_STAGES; k++) begin
        scl_sh[k] <= scl_sh[k-1];
        sda_sh[k] <= sda_sh[k-1];
      end
      scl_q <= scl_sh[SYNC_STAGES-1];
      sda_q <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[SYNC_STAGES-1];
  assign sda_lvl   = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2c_addr_ptr.sv
module i2c_addr_ptr #(
  parameter int ADDR_W   = 12,
  parameter int SMALL_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_mode,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic              inc,
  input  logic [7:0]        byte_in,
  output logic [ADDR_W-1:0] addr
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] SMALL_MASK = ADDR_W'((1 << SMALL_AW) - 1);

  logic [ADDR_W-1:0] ptr_q, ptr_d, mask;

  assign mask = big_mode ? '1 : SMALL_MASK;

  always_comb begin
    ptr_d = ptr_q;
    if (ld_hi)     ptr_d[ADDR_W-1:8] = byte_in[HI_W-1:0];
    else if (ld_lo) ptr_d[7:0]       = byte_in;
    else if (inc)  ptr_d             = (ptr_q + 1'b1) & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign addr = ptr_q & mask;

  p_wrap_small_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_hi && !ld_lo && !big_mode && ptr_q[SMALL_AW-1:0] == '1)
      |=> (addr == '0));
  p_wrap_big_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_hi && !ld_lo && big_mode && ptr_q == '1) |=> (ptr_q == '0));
  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !ld_hi && !ld_lo) |=> $stable(ptr_q));
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR    = 6'h2D,
  parameter int         ADDR_W      = 12,
  parameter int         SMALL_AW    = 11,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              big_mode,
  output logic              sda_oe,
  output logic              ram_we,
  output logic              ram_rd,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic rst_ns;
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  phase_t            phase_q, phase_d;
  bkind_t            kind_q, kind_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [7:0]        shreg_q, shreg_d, txreg_q, txreg_d;
  logic              oe_q, oe_d, rw_q, rw_d, rd_pend_q;
  logic              wr_stb, rd_stb, ld_hi, ld_lo, ptr_inc;

  i2c_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  i2c_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_ns), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_addr_ptr #(.ADDR_W(ADDR_W), .SMALL_AW(SMALL_AW)) u_ptr (
    .clk(clk), .rst_n(rst_ns), .big_mode(big_mode), .ld_hi(ld_hi),
    .ld_lo(ld_lo), .inc(ptr_inc), .byte_in(shreg_q), .addr(ram_addr)
  );

  // Byte sequencer: next-state logic
  always_comb begin
    phase_d = phase_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    txreg_d = rd_pend_q ? ram_rdata : txreg_q;
    oe_d    = oe_q;
    rw_d    = rw_q;
    wr_stb  = 1'b0;
    rd_stb  = 1'b0;
    ld_hi   = 1'b0;
    ld_lo   = 1'b0;
    if (stop_det) begin
      phase_d = PH_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      phase_d = PH_RX;
      kind_d  = BK_CTRL;
      cnt_d   = '0;
      oe_d    = 1'b0;
      rw_d    = 1'b0;
    end else begin
      unique case (phase_q)
        PH_RX: begin
          if (scl_rise && cnt_q != FULL) begin
            shreg_d = {shreg_q[6:0], sda_lvl};
            cnt_d   = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            cnt_d   = '0;
            phase_d = PH_ACK;
            oe_d    = 1'b1;
            unique case (kind_q)
              BK_CTRL: begin
                if (shreg_q[7:2] == DEV_ADDR) begin
                  rw_d   = shreg_q[0];
                  rd_stb = shreg_q[0];
                  kind_d = BK_AHI;
                end else begin
                  phase_d = PH_SKIP;
                  oe_d    = 1'b0;
                end
              end
              BK_AHI: begin
                ld_hi  = 1'b1;
                kind_d = BK_ALO;
              end
              BK_ALO: begin
                ld_lo  = 1'b1;
                kind_d = BK_DATA;
              end
              default: wr_stb = 1'b1;
            endcase
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              phase_d = PH_TX;
              oe_d    = ~txreg_q[7];
            end else begin
              phase_d = PH_RX;
              oe_d    = 1'b0;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (cnt_q == LAST) begin
              phase_d = PH_RACK;
              cnt_d   = '0;
              oe_d    = 1'b0;
            end else begin
              txreg_d = {txreg_q[6:0], 1'b0};
              cnt_d   = cnt_q + 1'b1;
              oe_d    = ~txreg_q[6];
            end
          end
        end
        PH_RACK: begin
          if (scl_rise && cnt_q == '0) begin
            if (!sda_lvl) begin
              rd_stb = 1'b1;
              cnt_d  = CNT_W'(1);
            end else begin
              phase_d = PH_SKIP;
            end
          end else if (scl_fall && cnt_q != '0) begin
            phase_d = PH_TX;
            cnt_d   = '0;
            oe_d    = ~txreg_q[7];
          end
        end
        default: ;
      endcase
    end
  end

  assign ptr_inc = wr_stb | rd_stb;

  // Byte sequencer: registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      phase_q   <= PH_IDLE;
      kind_q    <= BK_CTRL;
      cnt_q     <= '0;
      shreg_q   <= '0;
      txreg_q   <= '0;
      oe_q      <= 1'b0;
      rw_q      <= 1'b0;
      rd_pend_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      kind_q    <= kind_d;
      cnt_q     <= cnt_d;
      shreg_q   <= shreg_d;
      txreg_q   <= txreg_d;
      oe_q      <= oe_d;
      rw_q      <= rw_d;
      rd_pend_q <= rd_stb;
    end
  end

  assign sda_oe    = oe_q;
  assign ram_we    = wr_stb;
  assign ram_rd    = rd_stb;
  assign ram_wdata = shreg_q;

  p_pull_low_scl_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(sda_oe) |-> !scl_lvl);
  p_skip_silent_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (phase_q == PH_SKIP) |-> (!sda_oe && !ram_we && !ram_rd));
  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    stop_det |=> (!sda_oe && phase_q == PH_IDLE));
  p_write_after_addr_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    ram_we |-> (kind_q == BK_DATA && !rw_q));
  p_ack_matched_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    (phase_q == PH_ACK && kind_q == BK_AHI) |-> sda_oe);
endmodule

// File: tb/sim_i2c_mem_target.sv
module sim_i2c_mem_target;
  localparam int H = 20;

  logic clk, rst_n, scl_m, sda_m, big_mode;
  logic sda_oe, ram_we, ram_rd;
  logic [11:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;
  logic sda_bus;
  logic [7:0] mem [4096];
  logic [7:0] exp_mem [4096];
  int n_chk, n_fail, oe_viol;
  logic prev_oe;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_mem_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .big_mode(big_mode), .sda_oe(sda_oe), .ram_we(ram_we), .ram_rd(ram_rd),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_rd) ram_rdata <= mem[ram_addr];
  end

  always @(posedge clk) begin
    if (sda_oe && !prev_oe && scl_m) oe_viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b0; wait_clk(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b1; wait_clk(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wait_clk(H);
      scl_m = 1'b1; wait_clk(H);
      scl_m = 1'b0; wait_clk(4);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; wait_clk(H);
    scl_m = 1'b1; wait_clk(H/2);
    acked = !sda_bus;
    wait_clk(H/2);
    scl_m = 1'b0; wait_clk(4);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wait_clk(H);
      scl_m = 1'b1; wait_clk(H/2);
      b = {b[6:0], sda_bus};
      wait_clk(H/2);
      scl_m = 1'b0; wait_clk(4);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    scl_m = 1'b0; wait_clk(4);
    sda_m = 1'b1;
  endtask

  task automatic set_ptr(input logic [7:0] hi, input logic [7:0] lo, input string req);
    bit a;
    send_byte(8'hB4, a); chk(a, req, a, 1);
    send_byte(hi, a);    chk(a, req, a, 1);
    send_byte(lo, a);    chk(a, req, a, 1);
  endtask

  task automatic t_reset();
    chk(!sda_oe, "R10 reset release", sda_oe, 0);
    chk(!ram_we && !ram_rd, "R2 reset no strobe", {ram_we, ram_rd}, 0);
  endtask

  task automatic t_write_4k();
    bit a;
    big_mode = 1'b1;
    bus_start();
    send_byte(8'hB6, a); chk(a, "R1 ctrl ack bit1 dontcare", a, 1);
    send_byte(8'hF3, a); chk(a, "R3 addr hi ack", a, 1);
    send_byte(8'h45, a); chk(a, "R3 addr lo ack", a, 1);
    send_byte(8'hA1, a); chk(a, "R4 data ack", a, 1);
    send_byte(8'hB2, a); chk(a, "R4 data ack", a, 1);
    send_byte(8'hC3, a); chk(a, "R4 data ack", a, 1);
    bus_stop();
    exp_mem[12'h345] = 8'hA1; exp_mem[12'h346] = 8'hB2; exp_mem[12'h347] = 8'hC3;
    chk(mem[12'h345] == 8'hA1, "R3 hi nibble only", mem[12'h345], 8'hA1);
    chk(mem[12'h346] == 8'hB2, "R4 increment", mem[12'h346], 8'hB2);
    chk(mem[12'h347] == 8'hC3, "R4 increment", mem[12'h347], 8'hC3);
    chk(mem[12'hF45] == exp_mem[12'hF45], "R3 upper bits ignored", mem[12'hF45], exp_mem[12'hF45]);
  endtask

  task automatic t_cur_read();
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hB5, a); chk(a, "R1 read ctrl ack", a, 1);
    recv_byte(1'b0, b);
    wait_clk(10);
    chk(!sda_oe, "R10 release after nack", sda_oe, 0);
    wait_clk(H);
    chk(!sda_oe, "R10 still released", sda_oe, 0);
    bus_stop();
    chk(b == exp_mem[12'h348], "R7 current address read", b, exp_mem[12'h348]);
    chk(!sda_oe, "R10 stop release", sda_oe, 0);
  endtask

  task automatic t_rand_read();
    bit a;
    logic [7:0] b;
    bus_start();
    set_ptr(8'h01, 8'h23, "R8 addr phase ack");
    bus_start();
    send_byte(8'hB5, a); chk(a, "R8 read ctrl ack", a, 1);
    recv_byte(1'b0, b);
    bus_stop();
    chk(b == exp_mem[12'h123], "R8 random read", b, exp_mem[12'h123]);
  endtask

  task automatic t_seq_read_wrap();
    bit a;
    logic [7:0] b0, b1, b2;
    big_mode = 1'b1;
    bus_start();
    set_ptr(8'h0F, 8'hFE, "R9 addr phase ack");
    bus_start();
    send_byte(8'hB5, a); chk(a, "R9 read ctrl ack", a, 1);
    recv_byte(1'b1, b0);
    recv_byte(1'b1, b1);
    recv_byte(1'b0, b2);
    bus_stop();
    chk(b0 == exp_mem[12'hFFE], "R9 seq byte0", b0, exp_mem[12'hFFE]);
    chk(b1 == exp_mem[12'hFFF], "R9 seq byte1", b1, exp_mem[12'hFFF]);
    chk(b2 == exp_mem[12'h000], "R6 wrap 0xFFF", b2, exp_mem[12'h000]);
  endtask

  task automatic t_write_2k();
    bit a;
    big_mode = 1'b0;
    bus_start();
    set_ptr(8'h07, 8'hFF, "R5 addr phase ack");
    send_byte(8'h5A, a); chk(a, "R5 data ack", a, 1);
    send_byte(8'h6B, a); chk(a, "R5 data ack", a, 1);
    bus_stop();
    exp_mem[12'h7FF] = 8'h5A; exp_mem[12'h000] = 8'h6B;
    chk(mem[12'h7FF] == 8'h5A, "R5 top byte", mem[12'h7FF], 8'h5A);
    chk(mem[12'h000] == 8'h6B, "R5 wrap 0x7FF", mem[12'h000], 8'h6B);
    chk(mem[12'h800] == exp_mem[12'h800], "R5 no 0x800", mem[12'h800], exp_mem[12'h800]);
  endtask

  task automatic t_mismatch();
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(8'h54, a); chk(!a, "R2 nack foreign addr", a, 0);
    send_byte(8'h00, a); chk(!a, "R2 ignored byte", a, 0);
    send_byte(8'h10, a); chk(!a, "R2 ignored byte", a, 0);
    send_byte(8'hEE, a); chk(!a, "R2 ignored byte", a, 0);
    bus_stop();
    chk(mem[12'h010] == exp_mem[12'h010], "R2 no write", mem[12'h010], exp_mem[12'h010]);
    bus_start();
    send_byte(8'hB5, a); chk(a, "R1 read ctrl ack", a, 1);
    recv_byte(1'b0, b);
    bus_stop();
    chk(b == exp_mem[12'h001], "R2 pointer untouched", b, exp_mem[12'h001]);
  endtask

  task automatic t_restart_mid();
    bit a;
    big_mode = 1'b1;
    bus_start();
    send_bits(8'hB4, 4);
    bus_start();
    set_ptr(8'h02, 8'h00, "R11 restart ack");
    send_byte(8'h77, a); chk(a, "R11 data ack", a, 1);
    bus_stop();
    exp_mem[12'h200] = 8'h77;
    chk(mem[12'h200] == 8'h77, "R11 restart mid byte", mem[12'h200], 8'h77);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; oe_viol = 0; prev_oe = 1'b0;
    scl_m = 1'b1; sda_m = 1'b1; big_mode = 1'b1; rst_n = 1'b0;
    ram_rdata = '0;
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(10);
    t_reset();
    t_write_4k();
    t_cur_read();
    t_rand_read();
    t_seq_read_wrap();
    t_write_2k();
    t_mismatch();
    t_restart_mid();
    chk(oe_viol == 0, "R11 pull only with SCL low", oe_viol, 0);
    finish_run();
  end
endmodule